// File: doc/BRIEF.md
# Address-Pair Bit Set/Clear Register

This block is a write-only bank of ten control bits on an 8-bit data, 16-bit address processor bus. The bus data carries no information for it. Each bit owns two adjacent addresses: a write strobe to the even one of the pair drives the bit to 0, and a strobe to the odd one drives it to 1. Software changes a multi-bit field by issuing one such write per bit. Each bit keeps its value between writes, independently of the others.

The bank holds a 3-bit display mode field and a 7-bit display offset field. The mode field is presented directly. The offset field forms the seven most significant bits of a 16-bit frame buffer start address, so that address always lands on a 512-byte boundary. The decode window is 20 addresses starting at `BASE_ADDR` (default `16'hFFC0`). The mode pairs come first, with bit 0 lowest. The offset pairs follow directly after them.

Top module: `pbsc_bank`

## Requirements
- R1: While `rst_ni` is low, all ten bits are 0, so `mode_o` is 0 and `fb_addr_o` is 0.
- R2: A strobed write to the even address of a bit's pair clears that bit to 0.
- R3: A strobed write to the odd address of a bit's pair sets that bit to 1.
- R4: Mode bit i (i = 0..2, `mode_o[i]`) is cleared at `BASE_ADDR + 2*i` and set at `BASE_ADDR + 2*i + 1`. With the default base these addresses are FFC0/FFC1, FFC2/FFC3 and FFC4/FFC5.
- R5: Offset bit j (j = 0..6) is cleared at `BASE_ADDR + 6 + 2*j` and set at `BASE_ADDR + 7 + 2*j`. With the default base these run from FFC6/FFC7 to FFD2/FFD3.
- R6: The value on `data_i` has no effect on any bit.
- R7: A strobed write to any address below `BASE_ADDR` or above `BASE_ADDR + 19` leaves all ten bits unchanged.
- R8: When `wr_i` is low, no bit changes, whatever the address.
- R9: `fb_addr_o` equals the offset bits in bits 15..9, with offset bit j in bit 9+j. Bits 8..0 of `fb_addr_o` are always 0.
- R10: A write that hits one bit leaves the other nine bits unchanged.
- R11: A write is sampled on a rising clock edge. Its effect appears on the outputs after that edge and is not visible before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Bus address |
| wr_i | input | 1 | Write strobe, sampled on the rising clock edge |
| data_i | input | 8 | Bus write data, ignored |
| mode_o | output | 3 | Display mode bits |
| fb_addr_o | output | 16 | Frame buffer start address, 512-byte aligned |

## Verification
Every stored bit reaches a port directly, with no further logic in between. A wrong internal state therefore shows up at `mode_o` or `fb_addr_o[15:9]` in the cycle right after the faulty write edge, and it stays there until that bit's pair is written again. A decode slip to a neighbouring pair, or a swap of set and clear, changes a visible bit at once. The bench compares both outputs after every bus cycle, so a stray change caused by an out-of-window, unstrobed or data-dependent write is caught in the same cycle it happens.

// File: rtl/pbsc_pkg.sv
package pbsc_pkg;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned MODE_BITS  = 3;
  localparam int unsigned OFS_BITS   = 7;
  localparam int unsigned FB_W       = 16;
  localparam logic [15:0] BASE_DFLT  = 16'hFFC0;

  typedef enum logic {
    ACT_CLR = 1'b0,
    ACT_SET = 1'b1
  } pair_act_e;
endpackage

// File: rtl/pbsc_decode.sv
module pbsc_decode #(
  parameter int unsigned ADDR_W    = pbsc_pkg::ADDR_W,
  parameter int unsigned NUM_BITS  = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(16'hFFC0)
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  output logic [NUM_BITS-1:0] clr_o,
  output logic [NUM_BITS-1:0] set_o
);
  import pbsc_pkg::*;
  localparam int unsigned SPAN = 2 * NUM_BITS;

  logic [ADDR_W-1:0] rel;
  logic              in_win;
  pair_act_e         act;

  assign rel    = addr_i - BASE_ADDR;
  assign in_win = wr_i && (addr_i >= BASE_ADDR) && (rel < ADDR_W'(SPAN));
  assign act    = pair_act_e'(rel[0]);

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_pair
    logic hit;
    assign hit      = in_win && (rel[ADDR_W-1:1] == (ADDR_W-1)'(i));
    assign clr_o[i] = hit && (act == ACT_CLR);
    assign set_o[i] = hit && (act == ACT_SET);
  end
endmodule

// File: rtl/pbsc_bit_cell.sv
module pbsc_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/pbsc_frame_map.sv
module pbsc_frame_map #(
  parameter int unsigned OFS_BITS = pbsc_pkg::OFS_BITS,
  parameter int unsigned FB_W     = pbsc_pkg::FB_W
) (
  input  logic [OFS_BITS-1:0] ofs_i,
  output logic [FB_W-1:0]     fb_addr_o
);
  localparam int unsigned ALIGN_SH = FB_W - OFS_BITS;
  assign fb_addr_o = {ofs_i, {ALIGN_SH{1'b0}}};
endmodule

// File: rtl/pbsc_bank.sv
module pbsc_bank #(
  parameter int unsigned ADDR_W    = pbsc_pkg::ADDR_W,
  parameter int unsigned DATA_W    = pbsc_pkg::DATA_W,
  parameter int unsigned MODE_BITS = pbsc_pkg::MODE_BITS,
  parameter int unsigned OFS_BITS  = pbsc_pkg::OFS_BITS,
  parameter int unsigned FB_W      = pbsc_pkg::FB_W,
  parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(pbsc_pkg::BASE_DFLT)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic [MODE_BITS-1:0] mode_o,
  output logic [FB_W-1:0]      fb_addr_o
);
  localparam int unsigned NUM_BITS = MODE_BITS + OFS_BITS;

  logic [NUM_BITS-1:0] clr_v, set_v, bits_q;
  logic                unused_data;

  // Bit value comes from the address; data is deliberately discarded.
  assign unused_data = ^data_i;

  pbsc_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_BITS (NUM_BITS),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr_i(addr_i),
    .wr_i  (wr_i),
    .clr_o (clr_v),
    .set_o (set_v)
  );

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
    pbsc_bit_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_v[i]),
      .set_i (set_v[i]),
      .q_o   (bits_q[i])
    );
  end

  assign mode_o = bits_q[MODE_BITS-1:0];

  pbsc_frame_map #(
    .OFS_BITS(OFS_BITS),
    .FB_W    (FB_W)
  ) u_map (
    .ofs_i    (bits_q[NUM_BITS-1:MODE_BITS]),
    .fb_addr_o(fb_addr_o)
  );
endmodule

// File: rtl/pbsc_checker.sv
module pbsc_checker #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned MODE_BITS = 3,
  parameter int unsigned OFS_BITS  = 7,
  parameter int unsigned FB_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(16'hFFC0)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 wr_i,
  input logic [MODE_BITS-1:0] mode_o,
  input logic [FB_W-1:0]      fb_addr_o
);
  localparam int unsigned NUM   = MODE_BITS + OFS_BITS;
  localparam int unsigned IDX_W = $clog2(NUM);
  localparam int unsigned SH    = FB_W - OFS_BITS;

  logic [NUM-1:0]   full, full_q, keep_mask;
  logic             hit, hit_q, odd_q;
  logic [IDX_W-1:0] idx, idx_q;
  int unsigned      a_int, b_int;

  assign full  = {fb_addr_o[FB_W-1 -: OFS_BITS], mode_o};
  assign a_int = int'(addr_i);
  assign b_int = int'(BASE_ADDR);
  assign hit   = wr_i && (a_int >= b_int) && (a_int < b_int + 2 * NUM);
  assign idx   = IDX_W'((a_int - b_int) / 2);
  assign keep_mask = ~(NUM'(1) << idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      odd_q  <= 1'b0;
      idx_q  <= '0;
      full_q <= '0;
    end else begin
      hit_q  <= hit;
      odd_q  <= addr_i[0];
      idx_q  <= hit ? idx : '0;
      full_q <= full;
    end
  end

  always @(posedge clk_i)
    if (rst_ni === 1'b0)
      p_reset_zero_r1: assert (mode_o == '0 && fb_addr_o == '0);

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q && !odd_q |-> !full[idx_q]);

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q && odd_q |-> full[idx_q]);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_q |-> full == full_q);

  p_align_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_addr_o[SH-1:0] == '0);

  p_others_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |-> ((full ^ full_q) & keep_mask) == '0);
endmodule

bind pbsc_bank pbsc_checker #(
  .ADDR_W   (ADDR_W),
  .MODE_BITS(MODE_BITS),
  .OFS_BITS (OFS_BITS),
  .FB_W     (FB_W),
  .BASE_ADDR(BASE_ADDR)
) u_pbsc_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .mode_o   (mode_o),
  .fb_addr_o(fb_addr_o)
);

// File: tb/pbsc_bank_tb_top.sv
`timescale 1ns/1ps
module pbsc_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  data = '0;
  logic [2:0]  mode_o;
  logic [15:0] fb_addr_o;
  logic [9:0]  mdl = '0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  pbsc_bank dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr),
    .data_i(data), .mode_o(mode_o), .fb_addr_o(fb_addr_o)
  );

  function automatic logic [9:0] step(logic [9:0] m, logic [15:0] a, logic w);
    int unsigned off;
    if (!w || a < 16'hFFC0 || a > 16'hFFD3) return m;
    off = int'(a - 16'hFFC0);
    m[off / 2] = a[0];
    return m;
  endfunction

  function automatic logic [15:0] fb_of(logic [9:0] m);
    return {m[9:3], 9'b0};
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " mode"}, {13'b0, mode_o}, {13'b0, mdl[2:0]});
    chk({req, " fb"}, fb_addr_o, fb_of(mdl));
  endtask

  // Called at a negedge; drives one bus cycle and returns at the next negedge.
  task automatic cyc(logic [15:0] a, logic [7:0] d, logic w);
    addr = a; data = d; wr = w;
    @(posedge clk);
    mdl = step(mdl, a, w);
    @(negedge clk);
    wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240131));
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk);

    // R3/R4/R5: set each bit through its odd address
    for (int i = 0; i < 10; i++) begin
      cyc(16'hFFC1 + 16'(2 * i), 8'($urandom), 1'b1);
      if (i < 3) chk("R3 R4 set mode bit", {15'b0, mode_o[i]}, 16'd1);
      else       chk("R3 R5 set offset bit", {15'b0, fb_addr_o[9 + i - 3]}, 16'd1);
      chk_all("R10 others");
    end
    chk("R9 all offsets set", fb_addr_o, 16'hFE00);

    // R11: no change before the edge, change after it
    addr = 16'hFFC0; data = 8'h5A; wr = 1'b1;
    #1 chk("R11 before edge", {13'b0, mode_o}, 16'd7);
    @(posedge clk);
    mdl = step(mdl, addr, 1'b1);
    @(negedge clk); wr = 1'b0;
    chk("R11 after edge", {13'b0, mode_o}, 16'd6);

    // R2: clear each bit through its even address
    for (int i = 1; i < 10; i++) begin
      cyc(16'hFFC0 + 16'(2 * i), 8'hFF, 1'b1);
      chk_all("R2 clear");
    end
    chk("R2 all clear", fb_addr_o, 16'h0000);

    // R6: data polarity must not matter
    cyc(16'hFFC2, 8'hFF, 1'b1);
    chk_all("R6 even with ones");
    cyc(16'hFFC3, 8'h00, 1'b1);
    chk("R6 odd with zeros", {13'b0, mode_o}, 16'd2);
    cyc(16'hFFD3, 8'h00, 1'b1);
    chk("R9 top offset bit", fb_addr_o, 16'h8000);
    cyc(16'hFFC7, 8'h00, 1'b1);
    chk("R5 R9 low offset bit", fb_addr_o, 16'h8200);

    // R7: window edges and aliases
    cyc(16'hFFBF, 8'h00, 1'b1); chk_all("R7 below window");
    cyc(16'hFFD4, 8'h00, 1'b1); chk_all("R7 above window");
    cyc(16'hFFD5, 8'h00, 1'b1); chk_all("R7 above window odd");
    cyc(16'h7FC1, 8'h00, 1'b1); chk_all("R7 alias");
    cyc(16'h0000, 8'h00, 1'b1); chk_all("R7 zero addr");
    chk("R7 value kept", fb_addr_o, 16'h8200);

    // R8: no strobe
    cyc(16'hFFC1, 8'h00, 1'b0);
    chk("R8 no strobe", {13'b0, mode_o}, 16'd2);
    cyc(16'hFFD2, 8'h00, 1'b0);
    chk("R8 no strobe fb", fb_addr_o, 16'h8200);

    // Random mix around the window
    for (int k = 0; k < 600; k++) begin
      logic [15:0] a;
      a = ($urandom % 4 == 0) ? 16'($urandom) : 16'hFFBC + 16'($urandom % 28);
      cyc(a, 8'($urandom), 1'($urandom % 5 != 0));
      chk_all("R10 random");
      chk("R9 random align", {7'b0, fb_addr_o[8:0]}, 16'h0000);
    end

    // R1: asynchronous reset mid-run
    cyc(16'hFFC5, 8'h00, 1'b1);
    rst_ni = 1'b0;
    mdl = '0;
    #1 chk_all("R1 mid-run reset");
    @(negedge clk);
    chk_all("R1 held reset");
    rst_ni = 1'b1;
    @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule